// File: doc/BRIEF.md
# Shadowed Peripheral Clock Gate Controller

This block holds the clock-gate enables for fifteen peripherals, kept separately for each of three processor power modes (run, sleep, deep sleep). A write names one peripheral, one mode and the new enable value. It lands only in a shadow copy. The live gates keep their old values until a single load strobe copies every shadow bit into the active set in one cycle. This lets software stage many gate changes and then apply them together.

The gate that leaves the block for each peripheral is the active enable of the mode the processor is in now, masked by the power-good flag of that peripheral's group. A small set of whole clock domains is handled the same way: a shadow bit per domain, applied on load, and masked by that domain's power-good input. A status flag reports whether the shadow state has been touched since the last load.

Top module: `gcg_top`

## Requirements
- R1: After reset every shadow and active enable is 0, so `gate_en` and `dom_clk_en` are all zero, and `load_done` is 1.
- R2: A peripheral identifier carries its group in bits [11:8] and its bit position in bits [4:0]; bits [7:5] must be zero. Group codes and sizes are 0: timers (4), 1: synchronous serial (2), 2: UART (2), 3: I2C (1), 4: security and DMA (4), 5: GPIO (1), 6: I2S (1). The peripheral drives `gate_en` bit (sum of the sizes of all lower groups) + position, which gives indices 0 to 14.
- R3: An accepted peripheral write changes only the shadow enable; `gate_en` stays as it was until a load.
- R4: When `load` is high at a clock edge, all shadow enables of all three modes become active at that edge. The new gates are visible in the following cycle.
- R5: `load_done` goes to 0 on the edge after any accepted peripheral or domain write. It goes to 1 on the edge after a load that has no accepted write in the same cycle.
- R6: A write is ignored if its identifier has an undefined group, an undefined position, or nonzero bits [7:5], or if `wr_mode` is 3. It changes no enable and leaves `load_done` unchanged.
- R7: `cpu_mode` selects the active set used for the gates: 0 is run, 1 is sleep, 2 is deep sleep. A value of 3 forces all of `gate_en` to 0.
- R8: Each `gate_en` bit equals the selected active enable ANDed with the `grp_pwr_good` bit of its group (bit index = group code).
- R9: Clock domain writes (`dom_idx` below DOM_CNT) update a shadow bit that becomes active on load. `dom_clk_en` is the active bit ANDed with `dom_pwr_good`. A domain index at or above DOM_CNT is ignored.
- R10: If a write and a load occur in the same cycle, the load copies the shadow state from before that write, the write still updates the shadow, and `load_done` becomes 0.
- R11: `wr_set` = 1 sets and `wr_set` = 0 clears exactly the one addressed enable. Every other enable keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Peripheral enable write strobe |
| wr_mode | input | 2 | Power mode the write targets (0 run, 1 sleep, 2 deep sleep) |
| wr_id | input | 12 | Peripheral identifier |
| wr_set | input | 1 | New enable value |
| dom_wr_en | input | 1 | Clock domain write strobe |
| dom_idx | input | DOM_IDX_W | Clock domain index |
| dom_set | input | 1 | New domain enable value |
| load | input | 1 | Copy all shadow enables to the active set |
| cpu_mode | input | 2 | Current processor power mode |
| grp_pwr_good | input | 7 | Power-good flag per peripheral group |
| dom_pwr_good | input | DOM_CNT | Power-good flag per clock domain |
| gate_en | output | 15 | Peripheral clock gate enables |
| dom_clk_en | output | DOM_CNT | Clock domain enables |
| load_done | output | 1 | 1 when no write has occurred since the last load |

## Verification
The assertions watch, on every cycle, that the active set moves only on a load and then equals the shadow state seen at the strobe. They also check that `load_done` follows writes and loads, that rejected identifiers leave the shadow untouched, and that mode 3 closes every gate. Two things only the bench scenarios can show: that each of the 512 group/position codes reaches the correct gate bit (or none), and that the power-good masking is right for every group pattern. The bench also covers the case where a write and a load share a cycle.

// File: rtl/gcg_pkg.sv
package gcg_pkg;
    localparam int GRP_CNT    = 7;
    localparam int PERIPH_CNT = 15;
    localparam int MODE_CNT   = 3;
    localparam int MODE_W     = 2;
    localparam int ID_W       = 12;
    localparam int GRP_LSB    = 8;
    localparam int GRP_W      = ID_W - GRP_LSB;
    localparam int POS_W      = 5;
    localparam int IDX_W      = $clog2(PERIPH_CNT);

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_DEEP  = 2'd2,
        MODE_NONE  = 2'd3
    } pwr_mode_e;

    typedef logic [PERIPH_CNT-1:0] gate_vec_t;
    typedef gate_vec_t [MODE_CNT-1:0] mode_set_t;

    // number of peripherals in each group
    function automatic int grp_width(input int g);
        case (g)
            0: return 4;
            1: return 2;
            2: return 2;
            3: return 1;
            4: return 4;
            5: return 1;
            6: return 1;
            default: return 0;
        endcase
    endfunction

    // first flat gate index of a group
    function automatic int grp_base(input int g);
        int acc;
        acc = 0;
        for (int k = 0; k < GRP_CNT; k++) begin
            if (k < g) acc += grp_width(k);
        end
        return acc;
    endfunction
endpackage

// File: rtl/gcg_id_decode.sv
module gcg_id_decode
    import gcg_pkg::*;
(
    input  logic [ID_W-1:0]  id,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    logic [GRP_W-1:0] grp;
    logic [POS_W-1:0] pos;
    logic             pad_zero;

    assign grp      = id[GRP_LSB +: GRP_W];
    assign pos      = id[POS_W-1:0];
    assign pad_zero = (id[GRP_LSB-1:POS_W] == '0);

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int g = 0; g < GRP_CNT; g++) begin
            if (pad_zero && (grp == GRP_W'(g)) && (int'(pos) < grp_width(g))) begin
                valid = 1'b1;
                idx   = IDX_W'(grp_base(g) + int'(pos));
            end
        end
    end

    always_comb begin
        if (valid) begin
            AST_IDX_IN_RANGE: assert (int'(idx) < PERIPH_CNT); // R2
        end
    end
endmodule

// File: rtl/gcg_gate_sel.sv
module gcg_gate_sel
    import gcg_pkg::*;
(
    input  pwr_mode_e          mode,
    input  mode_set_t          active,
    input  logic [GRP_CNT-1:0] grp_pg,
    output gate_vec_t          gate
);
    gate_vec_t pg_flat;
    gate_vec_t sel;

    for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
        for (genvar b = 0; b < grp_width(g); b++) begin : g_bit
            assign pg_flat[grp_base(g) + b] = grp_pg[g];
        end
    end

    always_comb begin
        case (mode)
            MODE_RUN:   sel = active[0];
            MODE_SLEEP: sel = active[1];
            MODE_DEEP:  sel = active[2];
            default:    sel = '0;
        endcase
        gate = sel & pg_flat;
    end
endmodule

// File: rtl/gcg_dom_ctl.sv
module gcg_dom_ctl #(
    parameter int DOM_CNT   = 2,
    parameter int DOM_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dom_wr,
    input  logic [DOM_IDX_W-1:0] dom_idx,
    input  logic                 dom_set,
    input  logic                 load,
    input  logic [DOM_CNT-1:0]   dom_pg,
    output logic [DOM_CNT-1:0]   dom_clk_en,
    output logic                 dom_accept
);
    typedef struct packed {
        logic [DOM_CNT-1:0] sh;
        logic [DOM_CNT-1:0] act;
    } dom_st_t;

    dom_st_t dom_d, dom_q;

    assign dom_accept = dom_wr && (int'(dom_idx) < DOM_CNT);

    always_comb begin
        dom_d = dom_q;
        if (load) dom_d.act = dom_q.sh;
        for (int d = 0; d < DOM_CNT; d++) begin
            if (dom_accept && (dom_idx == DOM_IDX_W'(d))) dom_d.sh[d] = dom_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dom_q <= '0;
        else        dom_q <= dom_d;
    end

    assign dom_clk_en = dom_q.act & dom_pg;

    AST_DOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dom_q.act)); // R9
    AST_DOM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dom_q.act == $past(dom_q.sh)); // R9
    AST_DOM_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_wr && !dom_accept) |=> $stable(dom_q.sh)); // R9
endmodule

// File: rtl/gcg_top.sv
module gcg_top
    import gcg_pkg::*;
#(
    parameter int DOM_CNT   = 2,
    parameter int DOM_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_mode,
    input  logic [11:0]          wr_id,
    input  logic                 wr_set,
    input  logic                 dom_wr_en,
    input  logic [DOM_IDX_W-1:0] dom_idx,
    input  logic                 dom_set,
    input  logic                 load,
    input  logic [1:0]           cpu_mode,
    input  logic [6:0]           grp_pwr_good,
    input  logic [DOM_CNT-1:0]   dom_pwr_good,
    output logic [14:0]          gate_en,
    output logic [DOM_CNT-1:0]   dom_clk_en,
    output logic                 load_done
);
    typedef struct packed {
        mode_set_t shadow;
        mode_set_t active;
        logic      done;
    } gate_st_t;

    gate_st_t         st_d, st_q;
    logic             id_valid;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_ok;
    logic             dom_changed;
    gate_vec_t        gate_w;

    gcg_id_decode i_dec (
        .id    (wr_id),
        .valid (id_valid),
        .idx   (wr_idx)
    );

    gcg_dom_ctl #(
        .DOM_CNT   (DOM_CNT),
        .DOM_IDX_W (DOM_IDX_W)
    ) i_dom (
        .clk        (clk),
        .rst_n      (rst_n),
        .dom_wr     (dom_wr_en),
        .dom_idx    (dom_idx),
        .dom_set    (dom_set),
        .load       (load),
        .dom_pg     (dom_pwr_good),
        .dom_clk_en (dom_clk_en),
        .dom_accept (dom_changed)
    );

    assign wr_ok = wr_en && id_valid && (int'(wr_mode) < MODE_CNT);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.active = st_q.shadow;
            st_d.done   = 1'b1;
        end
        for (int m = 0; m < MODE_CNT; m++) begin
            if (wr_ok && (wr_mode == MODE_W'(m))) st_d.shadow[m][wr_idx] = wr_set;
        end
        if (wr_ok || dom_changed) st_d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shadow <= '0;
            st_q.active <= '0;
            st_q.done   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    gcg_gate_sel i_sel (
        .mode   (pwr_mode_e'(cpu_mode)),
        .active (st_q.active),
        .grp_pg (grp_pwr_good),
        .gate   (gate_w)
    );

    assign gate_en   = gate_w;
    assign load_done = st_q.done;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.active)); // R3
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> st_q.active == $past(st_q.shadow)); // R4
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_ok && !dom_changed) |=> load_done); // R5
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok || dom_changed) |=> !load_done); // R5
    AST_BAD_ID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !id_valid && !dom_wr_en && !load) |=> ($stable(st_q.shadow) && $stable(load_done))); // R6
    AST_MODE_NONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mode == 2'd3) |-> (gate_en == '0)); // R7
endmodule

// File: tb/test_gcg_top.sv
module test_gcg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_mode = '0;
    logic [11:0] wr_id = '0;
    logic        wr_set = 1'b0;
    logic        dom_wr_en = 1'b0;
    logic [1:0]  dom_idx = '0;
    logic        dom_set = 1'b0;
    logic        load = 1'b0;
    logic [1:0]  cpu_mode = '0;
    logic [6:0]  grp_pwr_good = '1;
    logic [1:0]  dom_pwr_good = '1;
    logic [14:0] gate_en;
    logic [1:0]  dom_clk_en;
    logic        load_done;

    int errors = 0;
    int checks = 0;

    logic [14:0] exp_sh  [3];
    logic [14:0] exp_act [3];
    logic [1:0]  exp_dsh;
    logic [1:0]  exp_dact;
    logic        exp_done;

    always #5 clk = ~clk;

    gcg_top i_gcg_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode), .wr_id(wr_id),
        .wr_set(wr_set), .dom_wr_en(dom_wr_en), .dom_idx(dom_idx), .dom_set(dom_set),
        .load(load), .cpu_mode(cpu_mode), .grp_pwr_good(grp_pwr_good),
        .dom_pwr_good(dom_pwr_good), .gate_en(gate_en), .dom_clk_en(dom_clk_en),
        .load_done(load_done)
    );

    function automatic int b_width(input int g);
        int w [7] = '{4, 2, 2, 1, 4, 1, 1};
        return (g < 7) ? w[g] : 0;
    endfunction

    function automatic int b_base(input int g);
        int s = 0;
        for (int k = 0; k < g; k++) s += b_width(k);
        return s;
    endfunction

    function automatic bit id_ok(input logic [11:0] id);
        int g = int'(id[11:8]);
        int p = int'(id[4:0]);
        return (id[7:5] == 3'b0) && (g < 7) && (p < b_width(g));
    endfunction

    function automatic logic [14:0] exp_gate(input int m);
        logic [14:0] pg = '0;
        if (m > 2) return '0;
        for (int g = 0; g < 7; g++)
            for (int b = 0; b < b_width(g); b++) pg[b_base(g) + b] = grp_pwr_good[g];
        return exp_act[m] & pg;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_gates(input string req);
        logic [1:0] keep = cpu_mode;
        for (int cm = 0; cm < 4; cm++) begin
            cpu_mode = 2'(cm);
            #1;
            chk(gate_en == exp_gate(cm), req, int'(gate_en), int'(exp_gate(cm)));
        end
        cpu_mode = keep;
    endtask

    task automatic check_done(input string req);
        chk(load_done == exp_done, req, int'(load_done), int'(exp_done));
    endtask

    task automatic model_write(input int m, input logic [11:0] id, input logic s);
        if (id_ok(id) && m < 3) begin
            exp_sh[m][b_base(int'(id[11:8])) + int'(id[4:0])] = s;
            exp_done = 1'b0;
        end
    endtask

    task automatic do_write(input int m, input logic [11:0] id, input logic s);
        wr_en = 1'b1; wr_mode = 2'(m); wr_id = id; wr_set = s;
        tick();
        wr_en = 1'b0;
        model_write(m, id, s);
    endtask

    task automatic do_load();
        load = 1'b1;
        tick();
        load = 1'b0;
        for (int m = 0; m < 3; m++) exp_act[m] = exp_sh[m];
        exp_dact = exp_dsh;
        exp_done = 1'b1;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int m = 0; m < 3; m++) begin exp_sh[m] = '0; exp_act[m] = '0; end
        exp_dsh = '0; exp_dact = '0; exp_done = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_gates("R1 gates after reset");
        check_done("R1 load_done after reset");
        chk(dom_clk_en == 2'b00, "R1 domains after reset", int'(dom_clk_en), 0);

        // R2 R3 R4 R5 R6 R7: sweep every group/position code in every write mode
        for (int g = 0; g < 16; g++) begin
            for (int b = 0; b < 32; b++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [11:0] id = {4'(g), 3'b000, 5'(b)};
                    do_write(m, id, 1'b1);
                    check_done("R5 R6 done after write");
                    check_gates("R3 gates held before load");
                    do_load();
                    check_done("R5 done after load");
                    check_gates("R2 R4 R7 gate after load");
                    do_write(m, id, 1'b0);
                    do_load();
                end
            end
        end

        // R6: nonzero pad bits are rejected
        for (int pad = 1; pad < 8; pad++) begin
            do_write(0, {4'd0, 3'(pad), 5'd0}, 1'b1);
            check_done("R6 pad bits ignored done");
            do_load();
            check_gates("R6 pad bits ignored gates");
        end

        // R11: set all in run mode, clear one, others kept
        for (int g = 0; g < 7; g++)
            for (int b = 0; b < b_width(g); b++) do_write(0, {4'(g), 3'b000, 5'(b)}, 1'b1);
        do_write(1, 12'h401, 1'b1);
        do_write(2, 12'h600, 1'b1);
        do_write(2, 12'h003, 1'b1);
        do_load();
        check_gates("R11 all set");
        do_write(0, 12'h201, 1'b0);
        do_load();
        check_gates("R11 single clear");

        // R8: all power-good patterns
        for (int p = 0; p < 128; p++) begin
            grp_pwr_good = 7'(p);
            check_gates("R8 power good mask");
        end
        grp_pwr_good = '1;

        // R10: write and load in the same cycle
        wr_en = 1'b1; wr_mode = 2'd1; wr_id = 12'h100; wr_set = 1'b1; load = 1'b1;
        tick();
        wr_en = 1'b0; load = 1'b0;
        for (int m = 0; m < 3; m++) exp_act[m] = exp_sh[m];
        model_write(1, 12'h100, 1'b1);
        check_done("R10 done after write+load");
        check_gates("R10 load used old shadow");
        do_load();
        check_gates("R10 later load applies write");
        check_done("R10 done after second load");

        // R9: clock domains
        for (int d = 0; d < 4; d++) begin
            dom_wr_en = 1'b1; dom_idx = 2'(d); dom_set = 1'b1;
            tick();
            dom_wr_en = 1'b0;
            if (d < 2) begin exp_dsh[d] = 1'b1; exp_done = 1'b0; end
            check_done("R9 done after domain write");
            chk(dom_clk_en == exp_dact, "R9 domain held before load", int'(dom_clk_en), int'(exp_dact));
            do_load();
            for (int p = 0; p < 4; p++) begin
                dom_pwr_good = 2'(p);
                #1;
                chk(dom_clk_en == (exp_dact & 2'(p)), "R9 domain after load", int'(dom_clk_en), int'(exp_dact & 2'(p)));
            end
            dom_pwr_good = '1;
        end
        dom_wr_en = 1'b1; dom_idx = 2'd0; dom_set = 1'b0;
        tick();
        dom_wr_en = 1'b0;
        exp_dsh[0] = 1'b0; exp_done = 1'b0;
        do_load();
        chk(dom_clk_en == exp_dact, "R9 domain cleared", int'(dom_clk_en), int'(exp_dact));

        report();
    end
endmodule